// File: doc/BRIEF.md
# DRAM Strobe Decoder With Parallel Test Mode

This block is a clocked, device-side stand-in for an asynchronous-strobe DRAM that has a four-bit data port. It samples the active-low row strobe, column strobe, write enable and output enable on every clock, together with the multiplexed address. From the order in which the strobe edges arrive, it sorts each access into one of these classes: read, early write, late write, row-only refresh, column-before-row refresh, or test-mode entry. It keeps a small parameterised array, an internal refresh row counter, and a parallel test mode. In that test mode one data bit is written to eight cells at once, and a read collapses the compare of those eight cells into an all-ones or all-zeros word.

A controller testbench connects its strobes to the block and checks its own sequences through a status output. That output gives the decoded class, the test-mode flag and the refresh counter. The block models only the order of edges. It checks no analog timing.

The row is taken from the low `ROW_W` address bits and the column from the low `COL_W` address bits. The array holds 2^(ROW_W+COL_W) words. Strobes are sampled on the rising clock edge, so a strobe transition is seen as a change between two consecutive samples.

Top module: `strobe_dram_model`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `dq_oe` is 0, `test_mode` is 0, `ref_row` is 0 and `cyc_type` is 0 (idle).
- R2: A row-strobe fall with the column strobe high latches the row. A later column-strobe fall latches the column. If `we_n` is high at that fall, the access is a read (`cyc_type` 1). The stored word appears on `dq_out` one clock after the fall. If `we_n` is low at that fall, the access is an early write (`cyc_type` 2) that stores `dq_in`.
- R3: `dq_oe` is 1 only in the cycle after a sample in which a read column access is open and both `cas_n` and `oe_n` are low. It returns to 0 one clock after either `cas_n` or `oe_n` is sampled high.
- R4: During an early write `dq_oe` stays 0 for the whole column access, even with `oe_n` low.
- R5: If `we_n` falls while a read column access is open, `dq_in` is stored at the latched row and column, and `cyc_type` becomes 3.
- R6: A row-strobe fall with the column strobe high sets `cyc_type` to 4. If the row strobe rises again with no column fall in between, the array and `ref_row` stay unchanged and `dq_oe` stays 0.
- R7: A row-strobe fall while the column strobe is already low is a refresh from the internal counter (`cyc_type` 5). The address is ignored, `dq_oe` stays 0, and `ref_row` steps by one, wrapping from 2^REF_W-1 to 0.
- R8: The same ordering with `we_n` low sets `cyc_type` to 6, sets `test_mode`, and also steps `ref_row`.
- R9: In test mode a write stores bit 0 of `dq_in` into all eight bits of the column pair: the even word and the odd word that differ only in column bit 0.
- R10: In test mode a read drives `dq_out` to all ones if the eight bits of the addressed column pair are all equal, and to all zeros otherwise.
- R11: `test_mode` is cleared by a column-before-row refresh with `we_n` high, or by a row-only cycle.
- R12: Several column accesses under one row-strobe low period all use the row latched at the row-strobe fall.
- R13: If the column strobe is held low after a read while the row strobe rises and falls again, a counter refresh runs (`cyc_type` 5, `ref_row` steps), and `dq_oe` and `dq_out` keep the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | A_W (10) | Multiplexed row/column address |
| dq_in | input | DQ_W (4) | Write data |
| dq_out | output | DQ_W (4) | Read data or test-mode compare result |
| dq_oe | output | 1 | High when the data port drives |
| cyc_type | output | 3 | Decoded access class (0 idle, 1 read, 2 early write, 3 late write, 4 row-only, 5 counter refresh, 6 test entry) |
| test_mode | output | 1 | Parallel test mode active |
| ref_row | output | REF_W (10) | Internal refresh row counter |

## Verification
The in-RTL properties check on every cycle that the driver never turns on without column and output enable sampled low, and that an early write keeps the port off. They also check that the refresh counter only ever moves by one step, and that test mode starts only on a test-entry class and ends only on a refresh class. Stored data is checked only by the bench's scenarios. These cover correct read-back after random page traffic, late-write data, the collapsed pass/fail word of the test mode, hidden refresh that keeps the read word on the port, and counter wrap.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE   = 3'd0,
    CYC_READ   = 3'd1,
    CYC_EWRITE = 3'd2,
    CYC_LWRITE = 3'd3,
    CYC_RONLY  = 3'd4,
    CYC_CBR    = 3'd5,
    CYC_TENTRY = 3'd6
  } cyc_e;
endpackage

// File: rtl/sdm_bank.sv
module sdm_bank #(
  parameter int DW = 4,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) rdata <= mem[idx];
  end
endmodule

// File: rtl/sdm_outmux.sv
module sdm_outmux #(
  parameter int DW = 4
) (
  input  logic [DW-1:0] rd_even,
  input  logic [DW-1:0] rd_odd,
  input  logic          sel_odd,
  input  logic          tm_rd,
  output logic [DW-1:0] dq_out
);
  logic [2*DW-1:0] both;
  logic            uniform;

  always_comb begin
    both    = {rd_odd, rd_even};
    uniform = (&both) | ~(|both);
    if (tm_rd)        dq_out = {DW{uniform}};
    else if (sel_odd) dq_out = rd_odd;
    else              dq_out = rd_even;
  end
endmodule

// File: rtl/sdm_ctrl.sv
module sdm_ctrl
  import sdm_pkg::*;
#(
  parameter int A_W   = 10,
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int REF_W = 10,
  parameter int IDX_W = ROW_W + COL_W - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [A_W-1:0]   addr,
  output logic [IDX_W-1:0] idx,
  output logic             wr_even,
  output logic             wr_odd,
  output logic             rd_en,
  output logic             sel_odd,
  output logic             tm_rd,
  output logic             dq_oe,
  output cyc_e             cyc_type,
  output logic             test_mode,
  output logic [REF_W-1:0] ref_row
);
  logic             ras_q, cas_q, we_q;
  logic             row_open, cas_seen, col_active, ew_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q, acc_col;
  logic             ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
  logic             is_cbr, col_go, late, wr_any;
  logic             col_act_d, ew_d;

  always_comb begin
    ras_fall = ras_q & ~ras_n;
    ras_rise = ~ras_q & ras_n;
    cas_fall = cas_q & ~cas_n;
    cas_rise = ~cas_q & cas_n;
    we_fall  = we_q & ~we_n;
    is_cbr   = ras_fall & ~cas_q;
    col_go   = cas_fall & row_open & ~ras_n;
    late     = we_fall & col_active & ~ew_q & row_open & ~cas_n & ~col_go;
    acc_col  = col_go ? addr[COL_W-1:0] : col_q;
    idx      = {row_q, acc_col[COL_W-1:1]};
    wr_any   = (col_go & ~we_n) | late;
    wr_even  = wr_any & (test_mode | ~acc_col[0]);
    wr_odd   = wr_any & (test_mode | acc_col[0]);
    rd_en    = col_go & we_n;
    if (col_go)        begin col_act_d = 1'b1; ew_d = ~we_n; end
    else if (cas_rise) begin col_act_d = 1'b0; ew_d = 1'b0;  end
    else               begin col_act_d = col_active; ew_d = ew_q; end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_q <= 1'b1; cas_q <= 1'b1; we_q <= 1'b1;
      row_open <= 1'b0; cas_seen <= 1'b0; col_active <= 1'b0; ew_q <= 1'b0;
      row_q <= '0; col_q <= '0; sel_odd <= 1'b0; tm_rd <= 1'b0;
      dq_oe <= 1'b0; cyc_type <= CYC_IDLE; test_mode <= 1'b0; ref_row <= '0;
    end else begin
      ras_q <= ras_n; cas_q <= cas_n; we_q <= we_n;
      col_active <= col_act_d;
      ew_q       <= ew_d;
      dq_oe      <= col_act_d & ~ew_d & ~oe_n & ~cas_n;
      if (is_cbr) begin
        ref_row <= ref_row + 1'b1;
        if (!we_n) begin test_mode <= 1'b1; cyc_type <= CYC_TENTRY; end
        else       begin test_mode <= 1'b0; cyc_type <= CYC_CBR;    end
      end else if (ras_fall) begin
        row_open <= 1'b1;
        row_q    <= addr[ROW_W-1:0];
        cas_seen <= 1'b0;
        cyc_type <= CYC_RONLY;
      end else if (ras_rise && row_open) begin
        row_open <= 1'b0;
        if (!cas_seen) test_mode <= 1'b0;
      end
      if (col_go) begin
        cas_seen <= 1'b1;
        col_q    <= addr[COL_W-1:0];
        sel_odd  <= addr[0];
        tm_rd    <= test_mode;
        cyc_type <= we_n ? CYC_READ : CYC_EWRITE;
      end
      if (late) cyc_type <= CYC_LWRITE;
    end
  end

  AST_REF_STEP: assert property (@(posedge clk) disable iff (rst)
    (ref_row != $past(ref_row)) |-> (ref_row == REF_W'($past(ref_row) + 1'b1))); // R7
  AST_TM_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(test_mode) |-> (cyc_type == CYC_TENTRY)); // R8
  AST_TM_EXIT: assert property (@(posedge clk) disable iff (rst)
    $fell(test_mode) |-> (cyc_type == CYC_CBR || cyc_type == CYC_RONLY)); // R11
endmodule

// File: rtl/strobe_dram_model.sv
module strobe_dram_model
  import sdm_pkg::*;
#(
  parameter int A_W   = 10,
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int REF_W = 10,
  parameter int DQ_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [A_W-1:0]   addr,
  input  logic [DQ_W-1:0]  dq_in,
  output logic [DQ_W-1:0]  dq_out,
  output logic             dq_oe,
  output logic [2:0]       cyc_type,
  output logic             test_mode,
  output logic [REF_W-1:0] ref_row
);
  localparam int IDX_W = ROW_W + COL_W - 1;

  logic [IDX_W-1:0] idx;
  logic             wr_even, wr_odd, rd_en, sel_odd, tm_rd;
  logic [DQ_W-1:0]  wdata;
  logic [DQ_W-1:0]  rdat [2];
  logic [1:0]       wr_bank;
  cyc_e             cyc_q;

  sdm_ctrl #(.A_W(A_W), .ROW_W(ROW_W), .COL_W(COL_W), .REF_W(REF_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .idx(idx), .wr_even(wr_even), .wr_odd(wr_odd), .rd_en(rd_en),
    .sel_odd(sel_odd), .tm_rd(tm_rd), .dq_oe(dq_oe), .cyc_type(cyc_q),
    .test_mode(test_mode), .ref_row(ref_row)
  );

  assign wdata    = test_mode ? {DQ_W{dq_in[0]}} : dq_in;
  assign wr_bank  = {wr_odd, wr_even};
  assign cyc_type = cyc_q;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    sdm_bank #(.DW(DQ_W), .AW(IDX_W)) u_bank (
      .clk(clk), .we(wr_bank[b]), .re(rd_en), .idx(idx), .wdata(wdata), .rdata(rdat[b])
    );
  end

  sdm_outmux #(.DW(DQ_W)) u_mux (
    .rd_even(rdat[0]), .rd_odd(rdat[1]), .sel_odd(sel_odd), .tm_rd(tm_rd), .dq_out(dq_out)
  );

  AST_OE_NEEDS_STROBES: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> $past(!oe_n && !cas_n)); // R3
  AST_EWRITE_HIZ: assert property (@(posedge clk) disable iff (rst)
    (cyc_type == 3'd2) |-> !dq_oe); // R4
endmodule

// File: tb/strobe_dram_model_bench.sv
module strobe_dram_model_bench;
  localparam int CLK_PERIOD = 10;
  localparam int B_ROW = 4;
  localparam int B_COL = 4;
  localparam int B_REF = 10;
  localparam int WORDS = 1 << (B_ROW + B_COL);

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [9:0] addr = '0;
  logic [3:0] dq_in = '0;
  logic [3:0] dq_out;
  logic       dq_oe;
  logic [2:0] cyc_type;
  logic       test_mode;
  logic [9:0] ref_row;

  int n_run = 0, n_fail = 0;
  int exp_ref = 0;
  int cur_row = 0;
  bit tm = 0;
  bit done = 0;
  logic [3:0] model [WORDS];

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_dram_model #(.A_W(10), .ROW_W(B_ROW), .COL_W(B_COL), .REF_W(B_REF), .DQ_W(4)) u_strobe_dram_model (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .cyc_type(cyc_type),
    .test_mode(test_mode), .ref_row(ref_row)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] tm_exp(int r, int c);
    logic [7:0] pair;
    pair = {model[r*16 + (c | 1)], model[r*16 + (c & 14)]};
    return (pair == 8'hFF || pair == 8'h00) ? 4'hF : 4'h0;
  endfunction

  task automatic open_row(int r);
    addr = 10'(r); ras_n = 1'b0; cur_row = r; step();
  endtask

  task automatic close_row();
    ras_n = 1'b1; step();
  endtask

  task automatic wr(int c, logic [3:0] d);
    addr = 10'(c); dq_in = d; we_n = 1'b0; oe_n = 1'b0; cas_n = 1'b0; step();
    check("R4 early write keeps port off", dq_oe, 0);
    check("R2 early write class", cyc_type, 2);
    cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; step();
    if (tm) begin
      model[cur_row*16 + (c & 14)] = {4{d[0]}};
      model[cur_row*16 + (c | 1)]  = {4{d[0]}};
    end else model[cur_row*16 + c] = d;
  endtask

  task automatic rd(int c, string req);
    logic [3:0] e;
    e = tm ? tm_exp(cur_row, c) : model[cur_row*16 + c];
    addr = 10'(c); we_n = 1'b1; oe_n = 1'b0; cas_n = 1'b0; step();
    check({req, " port enabled"}, dq_oe, 1);
    check({req, " data"}, dq_out, e);
    check("R2 read class", cyc_type, 1);
    cas_n = 1'b1; oe_n = 1'b1; step();
    check("R3 port off after strobe rise", dq_oe, 0);
  endtask

  task automatic cbr(logic w);
    cas_n = 1'b0; we_n = w; addr = 10'($urandom); step();
    ras_n = 1'b0; step();
    exp_ref = (exp_ref + 1) % 1024;
    check(w ? "R7 counter refresh class" : "R8 test entry class", cyc_type, w ? 5 : 6);
    check("R7 counter step", ref_row, exp_ref);
    check("R7 port off", dq_oe, 0);
    check(w ? "R11 test cleared" : "R8 test set", test_mode, w ? 0 : 1);
    tm = !w;
    ras_n = 1'b1; step();
    cas_n = 1'b1; we_n = 1'b1; step();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    step(); step();
    check("R1 reset port", dq_oe, 0);
    check("R1 reset test", test_mode, 0);
    check("R1 reset counter", ref_row, 0);
    check("R1 reset class", cyc_type, 0);
    rst = 1'b0; step();
    check("R1 after release class", cyc_type, 0);
    check("R1 after release counter", ref_row, 0);

    // R12 page fill of every row
    for (int r = 0; r < 16; r++) begin
      open_row(r);
      for (int c = 0; c < 16; c++) wr(c, 4'($urandom));
      close_row();
    end
    open_row(5); rd(3, "R12 page"); rd(12, "R12 page"); rd(7, "R12 page"); close_row();

    // R3 output enable gating
    open_row(2);
    addr = 10'd6; we_n = 1'b1; oe_n = 1'b1; cas_n = 1'b0; step();
    check("R3 off while oe high", dq_oe, 0);
    oe_n = 1'b0; step();
    check("R3 on with oe low", dq_oe, 1);
    check("R3 data", dq_out, model[2*16 + 6]);
    oe_n = 1'b1; step();
    check("R3 off after oe rise", dq_oe, 0);
    cas_n = 1'b1; step(); close_row();

    // R5 late write
    open_row(9);
    addr = 10'd4; we_n = 1'b1; oe_n = 1'b0; cas_n = 1'b0; step();
    check("R5 read before late write", dq_out, model[9*16 + 4]);
    we_n = 1'b0; dq_in = 4'hA; step();
    check("R5 late write class", cyc_type, 3);
    model[9*16 + 4] = 4'hA;
    cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; step();
    rd(4, "R5 late write readback"); close_row();

    // R6 row-only refresh
    open_row(9);
    check("R6 row-only class", cyc_type, 4);
    check("R6 port off", dq_oe, 0);
    close_row();
    check("R6 counter unchanged", ref_row, exp_ref);
    open_row(9); rd(4, "R6 contents kept"); close_row();

    // R7 counter refresh
    cbr(1'b1);
    cbr(1'b1);

    // R13 hidden refresh
    open_row(1);
    addr = 10'd8; we_n = 1'b1; oe_n = 1'b0; cas_n = 1'b0; step();
    check("R13 read data", dq_out, model[16 + 8]);
    ras_n = 1'b1; step();
    ras_n = 1'b0; step();
    exp_ref = (exp_ref + 1) % 1024;
    check("R13 hidden class", cyc_type, 5);
    check("R13 hidden counter", ref_row, exp_ref);
    check("R13 port stays on", dq_oe, 1);
    check("R13 data kept", dq_out, model[16 + 8]);
    ras_n = 1'b1; cas_n = 1'b1; oe_n = 1'b1; step();
    check("R13 port off", dq_oe, 0);

    // R8-R11 test mode
    open_row(3); wr(10, 4'hF); wr(11, 4'hE); close_row();
    cbr(1'b0);
    open_row(3);
    rd(10, "R10 mismatch pair");
    check("R10 mismatch gives zeros", dq_out, 0);
    wr(11, 4'h1);
    rd(10, "R10 pair after R9 write ones");
    check("R9 ones collapse", dq_out, 4'hF);
    wr(10, 4'h0);
    rd(11, "R9 zeros written to pair");
    close_row();
    open_row(3); close_row();
    check("R11 row-only clears test", test_mode, 0);
    tm = 0;
    open_row(3); rd(10, "R9 even word"); rd(11, "R9 odd word"); close_row();
    cbr(1'b0);
    cbr(1'b1);

    // random page traffic
    for (int i = 0; i < 80; i++) begin
      open_row(int'($urandom_range(15)));
      for (int k = 0; k < int'($urandom_range(3, 1)); k++) begin
        if ($urandom_range(1) == 1) wr(int'($urandom_range(15)), 4'($urandom));
        else rd(int'($urandom_range(15)), "R2 random read");
      end
      close_row();
    end

    // R7 wrap of the counter
    while (exp_ref != 1023) cbr(1'b1);
    check("R7 counter at top", ref_row, 1023);
    cbr(1'b1);
    check("R7 counter wrapped", ref_row, 0);

    summary();
  end
endmodule